// File: doc/BRIEF.md
# Sampling Converter Serial Sequencer

This block is the digital control side of a 16-bit successive-approximation sampling converter. It watches three slow control inputs: a sample request, a conversion clock and a calibration request. It takes the result word from a SAR datapath stub, which presents the word in parallel with a load strobe. It drives a busy flag, a serial data line and a serial data clock. An acquisition lasts while the sample request is high. The falling edge of the sample request commits a conversion. The next 17 valid conversion-clock rising edges then run it, and the word leaves the block MSB first as two's complement bits.

A raised calibration request is a hard reset of the sequence. It abandons whatever is running and holds busy high. When the request drops, a calibration period of fixed length begins, counted in conversion-clock rising edges. During that period the serial clock keeps pulsing. The serial data line carries an alternating test pattern, or a low level while the sample request is high. A flag marks that calibration has just ended, and it stays set until the first conversion after calibration has completed.

Everything runs on one fast system clock. The three control inputs are synchronised and edge-detected inside the block before any logic uses them. Every output comes from a register.

Top module: `adc_serial_seq`

## Requirements
- R1: After a synchronous reset, busy, serial data, serial clock and the calibration-done flag are all low.
- R2: A conversion shifts out the word that the last load strobe captured before the sample request fell. A load strobe after that fall does not change the bits shifted out.
- R3: Conversion-clock rising edges with no committed sample leave busy low. After a commit, busy rises on the first conversion-clock rising edge and falls on the 17th.
- R4: On each of the first 16 conversion-clock rising edges of a conversion, the serial data line takes the next result bit, starting with bit 15, and the serial clock goes low. The serial clock rises DCLK_DLY system cycles later, so 16 serial clock rising edges frame the 16 bits.
- R5: Toggling the sample request during a committed conversion has no effect on the bits or on when busy falls.
- R6: While busy is low, conversion-clock edges leave busy, serial data and serial clock unchanged.
- R7: If the sample request is already high when busy falls, acquisition has already begun, and a fall of the sample request with no new rise commits the next conversion.
- R8: While the calibration request is high, busy is high and serial data and serial clock are low. This holds even in the middle of a conversion, and conversion-clock edges have no effect.
- R9: After the calibration request falls, busy stays high through CAL_LEN-1 conversion-clock rising edges and falls on edge CAL_LEN.
- R10: During calibration, the serial clock rises after each conversion-clock rising edge. Serial data is low while the sample request is high. Otherwise, after the k-th edge it is 1 for odd k and 0 for even k.
- R11: The calibration-done flag rises at the moment busy falls at the end of calibration. It clears when the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Sample request; high acquires, falling edge commits |
| cnv_clk_i | input | 1 | Conversion clock; its rising edges step the sequence |
| cal_i | input | 1 | Calibration request; high is a hard reset |
| sar_word_i | input | DATA_W | Result word from the SAR stub |
| sar_load_i | input | 1 | Strobe that captures sar_word_i |
| busy_o | output | 1 | Conversion or calibration in progress |
| dout_o | output | 1 | Serial data, MSB first |
| dout_clk_o | output | 1 | Serial data clock; data is stable at its rising edge |
| cal_done_o | output | 1 | Calibration finished; no conversion has completed since |

## Verification
The bench checks the 17th edge closely. An off-by-one counter would end busy one edge early or late, or would shift an extra bit. It loads a different word just after the commit, which catches a design that copies the result late. It toggles the sample request in mid-conversion, which would restart or corrupt the shift in a design that does not lock out that input. It also holds the sample request high across the fall of busy, and a design that waits for a fresh rising edge would then never commit. It aborts a conversion with a calibration request, checks the pattern and the forced-low data, and checks that the done flag outlives calibration until exactly one conversion has completed.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_ARMED,
    ST_CONV,
    ST_CAL_HOLD,
    ST_CAL_RUN
  } seq_state_t;

  // bit positions of the control inputs inside the synchroniser vector
  localparam int CTL_SMP = 0;
  localparam int CTL_CLK = 1;
  localparam int CTL_CAL = 2;
  localparam int CTL_N   = 3;

endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);

  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign lvl_o  = stg[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CAL_LEN = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_lvl,
  input  logic smp_fall,
  input  logic tick,
  input  logic cal_lvl,
  input  logic cal_fall,
  output logic busy_o,
  output logic cal_flag_o,
  output logic load_o,
  output logic shift_o,
  output logic cal_tick_o,
  output logic cal_bit_o,
  output logic in_cal_o
);

  localparam int CONV_CLKS = DATA_W + 1;
  localparam int CAL_W     = $clog2(CAL_LEN + 1);
  localparam int CONV_W    = $clog2(CONV_CLKS + 1);
  localparam int CNT_W     = (CAL_W > CONV_W) ? CAL_W : CONV_W;
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CLKS - 1);
  localparam logic [CNT_W-1:0] CAL_LAST  = CNT_W'(CAL_LEN - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             busy_q;
  logic             flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      busy_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (cal_lvl) begin
      state  <= ST_CAL_HOLD;
      cnt    <= '0;
      busy_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (smp_lvl) state <= ST_ACQ;
        ST_ACQ: if (smp_fall) state <= ST_ARMED;
        ST_ARMED: if (tick) begin
          busy_q <= 1'b1;
          cnt    <= CNT_W'(1);
          state  <= ST_CONV;
        end
        ST_CONV: if (tick) begin
          if (cnt == CONV_LAST) begin
            busy_q <= 1'b0;
            flag_q <= 1'b0;
            cnt    <= '0;
            state  <= smp_lvl ? ST_ACQ : ST_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_CAL_HOLD: if (cal_fall) state <= ST_CAL_RUN;
        ST_CAL_RUN: if (tick) begin
          if (cnt == CAL_LAST) begin
            busy_q <= 1'b0;
            flag_q <= 1'b1;
            cnt    <= '0;
            state  <= smp_lvl ? ST_ACQ : ST_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    load_o     = !cal_lvl && (state == ST_ACQ) && smp_fall;
    shift_o    = !cal_lvl && tick &&
                 ((state == ST_ARMED) || ((state == ST_CONV) && (cnt != CONV_LAST)));
    cal_tick_o = !cal_lvl && tick && (state == ST_CAL_RUN);
    cal_bit_o  = ~cnt[0];
    in_cal_o   = (state == ST_CAL_HOLD) || (state == ST_CAL_RUN);
  end

  assign busy_o     = busy_q;
  assign cal_flag_o = flag_q;

endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out #(
  parameter int DATA_W   = 16,
  parameter int DCLK_DLY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sar_word,
  input  logic              sar_load,
  input  logic              clear,
  input  logic              load,
  input  logic              shift,
  input  logic              cal_tick,
  input  logic              cal_bit,
  input  logic              force_low,
  output logic              dout_o,
  output logic              dclk_o
);

  localparam int TW = $clog2(DCLK_DLY + 1);

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] sreg;
  logic [TW-1:0]     tmr;
  logic              dout_q;
  logic              dclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      sreg   <= '0;
      tmr    <= '0;
      dout_q <= 1'b0;
      dclk_q <= 1'b0;
    end else begin
      if (sar_load) hold_q <= sar_word;
      if (clear) begin
        sreg   <= '0;
        tmr    <= '0;
        dout_q <= 1'b0;
        dclk_q <= 1'b0;
      end else begin
        if (load) sreg <= hold_q;
        if (shift) begin
          dout_q <= sreg[DATA_W-1];
          sreg   <= {sreg[DATA_W-2:0], 1'b0};
          dclk_q <= 1'b0;
          tmr    <= TW'(DCLK_DLY);
        end else if (cal_tick) begin
          dout_q <= cal_bit;
          dclk_q <= 1'b0;
          tmr    <= TW'(DCLK_DLY);
        end else if (tmr != '0) begin
          tmr <= tmr - TW'(1);
          if (tmr == TW'(1)) dclk_q <= 1'b1;
        end
        if (force_low) dout_q <= 1'b0;
      end
    end
  end

  assign dout_o = dout_q;
  assign dclk_o = dclk_q;

endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CAL_LEN     = 4096,
  parameter int DCLK_DLY    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_sys,
  input  logic              rst,
  input  logic              sample_i,
  input  logic              cnv_clk_i,
  input  logic              cal_i,
  input  logic [DATA_W-1:0] sar_word_i,
  input  logic              sar_load_i,
  output logic              busy_o,
  output logic              dout_o,
  output logic              dout_clk_o,
  output logic              cal_done_o
);

  logic [CTL_N-1:0] ctl_raw, ctl_lvl, ctl_prev;
  logic smp_lvl, smp_fall, tick, cal_lvl, cal_fall;
  logic load, shift, cal_tick, cal_bit, in_cal, force_low;

  always_comb begin
    ctl_raw          = '0;
    ctl_raw[CTL_SMP] = sample_i;
    ctl_raw[CTL_CLK] = cnv_clk_i;
    ctl_raw[CTL_CAL] = cal_i;
  end

  adc_in_sync #(.N(CTL_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_sys), .rst(rst), .async_i(ctl_raw),
    .lvl_o(ctl_lvl), .prev_o(ctl_prev)
  );

  assign smp_lvl  = ctl_lvl[CTL_SMP];
  assign smp_fall = ~ctl_lvl[CTL_SMP] & ctl_prev[CTL_SMP];
  assign tick     = ctl_lvl[CTL_CLK] & ~ctl_prev[CTL_CLK];
  assign cal_lvl  = ctl_lvl[CTL_CAL];
  assign cal_fall = ~ctl_lvl[CTL_CAL] & ctl_prev[CTL_CAL];

  adc_seq_ctrl #(.DATA_W(DATA_W), .CAL_LEN(CAL_LEN)) u_ctrl (
    .clk(clk_sys), .rst(rst),
    .smp_lvl(smp_lvl), .smp_fall(smp_fall), .tick(tick),
    .cal_lvl(cal_lvl), .cal_fall(cal_fall),
    .busy_o(busy_o), .cal_flag_o(cal_done_o),
    .load_o(load), .shift_o(shift), .cal_tick_o(cal_tick),
    .cal_bit_o(cal_bit), .in_cal_o(in_cal)
  );

  assign force_low = in_cal & smp_lvl;

  adc_shift_out #(.DATA_W(DATA_W), .DCLK_DLY(DCLK_DLY)) u_shift (
    .clk(clk_sys), .rst(rst),
    .sar_word(sar_word_i), .sar_load(sar_load_i),
    .clear(cal_lvl), .load(load), .shift(shift),
    .cal_tick(cal_tick), .cal_bit(cal_bit), .force_low(force_low),
    .dout_o(dout_o), .dclk_o(dout_clk_o)
  );

endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic cal_lvl,
  input logic in_cal,
  input logic busy_o,
  input logic dout_o,
  input logic dout_clk_o,
  input logic cal_done_o
);

  // R3
  busy_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ($past(tick) || $past(cal_lvl)));

  // R8
  cal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cal_lvl |=> (busy_o && !dout_o && !dout_clk_o));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_o != $past(dout_o)) |-> (busy_o || $past(busy_o)));

  // R4
  data_setup_chk: assert property (@(posedge clk) disable iff (rst)
    ((dout_o != $past(dout_o)) && !in_cal) |-> !dout_clk_o);

  // R11
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_done_o) |-> $fell(busy_o));

endmodule

bind adc_serial_seq adc_serial_seq_chk u_chk (
  .clk(clk_sys), .rst(rst), .tick(tick), .cal_lvl(cal_lvl), .in_cal(in_cal),
  .busy_o(busy_o), .dout_o(dout_o), .dout_clk_o(dout_clk_o), .cal_done_o(cal_done_o)
);

// File: tb/adc_serial_seq_tb.sv
module adc_serial_seq_tb_top;

  localparam int W   = 16;
  localparam int CAL = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample = 1'b0, cnv_clk = 1'b0, cal = 1'b0, sar_load = 1'b0;
  logic [W-1:0] sar_word = '0;
  logic busy, dout, dclk, cal_done;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_serial_seq #(.DATA_W(W), .CAL_LEN(CAL), .DCLK_DLY(2), .SYNC_STAGES(2)) dut_i (
    .clk_sys(clk), .rst(rst), .sample_i(sample), .cnv_clk_i(cnv_clk), .cal_i(cal),
    .sar_word_i(sar_word), .sar_load_i(sar_load),
    .busy_o(busy), .dout_o(dout), .dout_clk_o(dclk), .cal_done_o(cal_done)
  );

  task automatic sys(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(logic [W-1:0] w, int k);
    return w[W-k];
  endfunction

  function automatic logic exp_cal(int k, bit smp_hi);
    return smp_hi ? 1'b0 : logic'(k % 2);
  endfunction

  // conversion clock pulses while nothing is committed: outputs hold (R3, R6)
  task automatic idle_pulses(int n);
    logic d0, c0;
    d0 = dout; c0 = dclk;
    for (int i = 0; i < n; i++) begin
      cnv_clk = 1'b1; sys(8);
      chk(busy == 1'b0, "R3 busy idle", busy, 0);
      chk(dout == d0 && dclk == c0, "R6 hold", {dout, dclk}, {d0, c0});
      cnv_clk = 1'b0; sys(8);
    end
  endtask

  task automatic run_conv(logic [W-1:0] w, bit pre_high, bit glitch,
                          bit late_load, bit end_high, string tag);
    sar_word = w; sar_load = 1'b1; sys(1); sar_load = 1'b0;
    if (!pre_high) begin sample = 1'b1; sys(10); end
    sample = 1'b0; sys(10);
    if (late_load) begin sar_word = ~w; sar_load = 1'b1; sys(1); sar_load = 1'b0; end
    for (int k = 1; k <= W + 1; k++) begin
      cnv_clk = 1'b1; sys(8);
      if (k <= W) begin
        chk(busy == 1'b1, {tag, " R3 busy during"}, busy, 1);
        chk(dout == exp_bit(w, k), {tag, " R2 R4 bit"}, dout, exp_bit(w, k));
        chk(dclk == 1'b1, {tag, " R4 dclk"}, dclk, 1);
      end else begin
        chk(busy == 1'b0, {tag, " R3 R5 busy after 17th"}, busy, 0);
      end
      cnv_clk = 1'b0;
      if (glitch && k == 5) begin sample = 1'b1; sys(4); sample = 1'b0; sys(4); end
      else sys(8);
      if (end_high && k == W) sample = 1'b1;
    end
  endtask

  initial begin
    logic [W-1:0] w;
    bit pend;
    sys(5); rst = 1'b0; sys(5);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(dout == 0, "R1 dout", dout, 0);
    chk(dclk == 0, "R1 dclk", dclk, 0);
    chk(cal_done == 0, "R1 flag", cal_done, 0);
    idle_pulses(3);

    run_conv(16'h8001, 0, 0, 0, 0, "dir");
    idle_pulses(2);
    run_conv(16'h7FFF, 0, 0, 1, 0, "R2 late");
    run_conv(16'hA5C3, 0, 1, 0, 0, "R5 glitch");
    run_conv(16'h8000, 0, 0, 0, 1, "end_hi");
    run_conv(16'h1234, 1, 0, 0, 0, "R7 prehigh");
    idle_pulses(2);

    void'($urandom(32'd1234));
    pend = 1'b0;
    for (int n = 0; n < 8; n++) begin
      bit eh;
      w  = W'($urandom);
      eh = ($urandom % 3) == 0;
      run_conv(w, pend, ($urandom % 2) == 1, ($urandom % 2) == 1, eh, "rand");
      pend = eh;
    end
    if (pend) begin sample = 1'b0; sys(10); end

    // abort a conversion with calibration
    sar_word = 16'hFFFF; sar_load = 1'b1; sys(1); sar_load = 1'b0;
    sample = 1'b1; sys(10); sample = 1'b0; sys(10);
    for (int k = 0; k < 5; k++) begin cnv_clk = 1'b1; sys(8); cnv_clk = 1'b0; sys(8); end
    cal = 1'b1; sys(10);
    chk(busy == 1 && dout == 0 && dclk == 0, "R8 abort", {busy, dout, dclk}, 3'b100);
    for (int k = 0; k < 4; k++) begin
      cnv_clk = 1'b1; sys(8);
      chk(busy == 1 && dclk == 0 && dout == 0, "R8 hold", {busy, dout, dclk}, 3'b100);
      cnv_clk = 1'b0; sys(8);
    end
    cal = 1'b0; sys(10);
    for (int k = 1; k <= CAL; k++) begin
      bit hi;
      hi = (k % 3) == 0;
      sample = hi; sys(6);
      cnv_clk = 1'b1; sys(8);
      chk(busy == (k < CAL), "R9 cal busy", busy, (k < CAL));
      chk(dout == exp_cal(k, hi), "R10 cal dout", dout, exp_cal(k, hi));
      chk(dclk == 1'b1, "R10 cal dclk", dclk, 1);
      cnv_clk = 1'b0; sample = 1'b0; sys(8);
    end
    chk(cal_done == 1, "R11 flag set", cal_done, 1);
    run_conv(16'h0F0F, 0, 0, 0, 0, "R11 dummy");
    chk(cal_done == 0, "R11 flag clear", cal_done, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule